// File: doc/BRIEF.md
# Two-Level Instruction Decode Controller

This block turns a 32-bit instruction word into the control word for a single-cycle load/store datapath. It works in two steps. A main decoder looks at the opcode in bits [31:26] and sets the datapath steering and write-enable signals. It also sets a 2-bit ALU class. A second decoder combines that class with the funct field in bits [5:0] and picks a 3-bit ALU operation code.

The block has no state, so its outputs follow the instruction combinationally. The supported instructions are load word, store word, branch-if-equal, jump, and register-register add, subtract, and, or and set-less-than. Any other opcode gives an inert control word: nothing is written, nothing branches and nothing jumps. The block builds none of the datapath around it.

Top module: `instr_decode_ctrl`

## Requirements
- R1: The opcode is taken only from bits [31:26] and the funct field only from bits [5:0]. Bits [25:6] have no effect on any output.
- R2: Opcode 000000 (register form) sets dst_sel_rd=1 and rf_we=1, clears every other single-bit control, and sets alu_cls=10.
- R3: Opcode 100011 (load) sets imm_sel, wb_from_mem, rf_we and dmem_re, clears the rest, and sets alu_cls=00 with alu_fn=010.
- R4: Opcode 101011 (store) sets imm_sel and dmem_we only, and sets alu_cls=00 with alu_fn=010.
- R5: Opcode 000100 (branch-if-equal) sets is_branch only, and sets alu_cls=01 with alu_fn=110.
- R6: Opcode 000010 (jump) sets is_jump only: no register or memory write, alu_cls=00.
- R7: Any other opcode drives every single-bit control to 0, with alu_cls=00 and alu_fn=010.
- R8: When alu_cls=10, alu_fn follows funct: 100000→010, 100010→110, 100100→000, 100101→001, 101010→111.
- R9: When alu_cls=10 and funct is none of the five codes above, alu_fn=010.
- R10: At most one of dmem_re, dmem_we, is_branch and is_jump is set at any time. A memory write never comes with a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being decoded |
| dst_sel_rd | output | 1 | Destination register from bits [15:11] (1) or bits [20:16] (0) |
| imm_sel | output | 1 | Second ALU operand is the sign-extended immediate |
| wb_from_mem | output | 1 | Register write data comes from data memory |
| rf_we | output | 1 | Register file write enable |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| is_branch | output | 1 | Conditional branch instruction |
| is_jump | output | 1 | Unconditional jump instruction |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 use funct |
| alu_fn | output | 3 | ALU operation code |

## Verification
The assertions assume only that the instruction word holds known 0/1 values. They treat every 6-bit opcode and funct value as legal, so unknown codes must also give a consistent inert or default word. The stimulus meets this by driving defined words only. It walks all 64 opcodes and all 64 funct values, and it fills bits [25:6] with random bits so that those bits are shown to have no effect.

// File: rtl/instr_decode_ctrl.sv
module instr_decode_ctrl #(
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr,
  output logic          dst_sel_rd,
  output logic          imm_sel,
  output logic          wb_from_mem,
  output logic          rf_we,
  output logic          dmem_re,
  output logic          dmem_we,
  output logic          is_branch,
  output logic          is_jump,
  output logic [1:0]    alu_cls,
  output logic [2:0]    alu_fn
);
  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  logic [5:0] opc, fn;
  logic [9:0] ctl;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    unique case (opc)
      OP_REG:  ctl = 10'b1001_0000_10;
      OP_LOAD: ctl = 10'b0111_1000_00;
      OP_STOR: ctl = 10'b0100_0100_00;
      OP_BEQ:  ctl = 10'b0000_0010_01;
      OP_JMP:  ctl = 10'b0000_0001_00;
      default: ctl = 10'b0000_0000_00;
    endcase
  end

  assign {dst_sel_rd, imm_sel, wb_from_mem, rf_we,
          dmem_re, dmem_we, is_branch, is_jump, alu_cls} = ctl;

  always_comb begin
    alu_fn = 3'b010;
    if (alu_cls == 2'b01) alu_fn = 3'b110;
    else if (alu_cls[1]) begin
      case (fn)
        6'b100010: alu_fn = 3'b110;
        6'b100100: alu_fn = 3'b000;
        6'b100101: alu_fn = 3'b001;
        6'b101010: alu_fn = 3'b111;
        default:   alu_fn = 3'b010;
      endcase
    end
  end
endmodule

module instr_decode_ctrl_chk (
  input logic [31:0] instr,
  input logic dst_sel_rd, imm_sel, wb_from_mem, rf_we,
  input logic dmem_re, dmem_we, is_branch, is_jump,
  input logic [1:0] alu_cls,
  input logic [2:0] alu_fn
);
  always_comb begin
    p_regform_dst_r2: assert (!dst_sel_rd || (rf_we && !imm_sel && alu_cls == 2'b10));
    p_load_wb_r3:     assert (!wb_from_mem || (dmem_re && rf_we && imm_sel));
    p_store_nowr_r4:  assert (!dmem_we || (!rf_we && imm_sel));
    p_branch_sub_r5:  assert (!is_branch || (alu_cls == 2'b01 && alu_fn == 3'b110));
    p_jump_inert_r6:  assert (!is_jump || (!rf_we && !dmem_we && !dmem_re));
    p_excl_r10:       assert ($onehot0({dmem_re, dmem_we, is_branch, is_jump}));
    p_cls_legal_r8:   assert (alu_cls != 2'b11);
    p_addcls_r7:      assert (alu_cls != 2'b00 || alu_fn == 3'b010);
  end
endmodule

bind instr_decode_ctrl instr_decode_ctrl_chk u_chk (.*);

// File: tb/tb_instr_decode_ctrl.sv
module tb_instr_decode_ctrl;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr;
  logic dst_sel_rd, imm_sel, wb_from_mem, rf_we, dmem_re, dmem_we, is_branch, is_jump;
  logic [1:0] alu_cls;
  logic [2:0] alu_fn;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  instr_decode_ctrl dut (.*);

  function automatic logic [12:0] model(input logic [31:0] w);
    int op = int'(w[31:26]);
    int f  = int'(w[5:0]);
    logic [7:0] b = 8'h00;
    logic [1:0] c = 2'd0;
    logic [2:0] a = 3'd2;
    if (op == 0) begin
      b = 8'b1001_0000; c = 2'd2;
      if (f == 34) a = 3'd6;
      else if (f == 36) a = 3'd0;
      else if (f == 37) a = 3'd1;
      else if (f == 42) a = 3'd7;
    end else if (op == 35) b = 8'b0111_1000;
    else if (op == 43) b = 8'b0100_0100;
    else if (op == 4) begin b = 8'b0000_0010; c = 2'd1; a = 3'd6; end
    else if (op == 2) b = 8'b0000_0001;
    return {b, c, a};
  endfunction

  function automatic string tag(input logic [31:0] w);
    case (w[31:26])
      6'd0:  return (w[5:0] inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd42}) ? "R2/R8" : "R2/R9";
      6'd35: return "R3";
      6'd43: return "R4";
      6'd4:  return "R5";
      6'd2:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input string req);
    logic [12:0] got, exp;
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    got = {dst_sel_rd, imm_sel, wb_from_mem, rf_we, dmem_re, dmem_we,
           is_branch, is_jump, alu_cls, alu_fn};
    exp = model(w);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h actual=%b expected=%b", req, w, got, exp);
    end
    n_chk++;
    if (!$onehot0({dmem_re, dmem_we, is_branch, is_jump}) || (dmem_we && rf_we)) begin
      n_bad++;
      $display("FAIL R10 instr=%h actual=%b expected=exclusive", w, got);
    end
  endtask

  initial begin
    instr = 32'h0;
    apply(32'h0, "R2/R8");
    apply({6'd0, 20'h0, 6'b100000}, "R8");
    apply({6'd0, 20'h0, 6'b100010}, "R8");
    apply({6'd0, 20'h0, 6'b100100}, "R8");
    apply({6'd0, 20'h0, 6'b100101}, "R8");
    apply({6'd0, 20'h0, 6'b101010}, "R8");
    apply({6'd35, 26'h0}, "R3");
    apply({6'd43, 26'h0}, "R4");
    apply({6'd4, 26'h0}, "R5");
    apply({6'd2, 26'h3ffffff}, "R6");
    apply({6'd63, 26'h0}, "R7");
    for (int op = 0; op < 64; op++)
      for (int k = 0; k < 4; k++)
        apply({6'(op), 20'($urandom), 6'($urandom)}, tag({6'(op), 26'h0}));
    for (int f = 0; f < 64; f++)
      apply({6'd0, 20'($urandom), 6'(f)}, tag({6'd0, 20'h0, 6'(f)}));
    for (int k = 0; k < 40; k++) begin
      logic [31:0] w = $urandom;
      apply(w, "R1");
      apply({w[31:26], ~w[25:6], w[5:0]}, "R1");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule